// File: doc/BRIEF.md
# Key-Locked Software Reset Trigger

This block lets software request a full device reset through a small register interface, with three hurdles in the way of a stray write. Software first opens a key lock by writing two fixed 32-bit words, in order, to a key register. Once the lock is open, a write of 1 to bit 0 of the reset-trigger register, or of its set alias, arms the trigger. A following read of the reset-trigger register fires the request. The request leaves the block as a one-cycle pulse to the reset sequencer. The sequencer treats it like a pin reset and records the software-reset flag in its own status register.

The register bus is a request/response stream. A request is taken on any clock edge where `req_valid` is high. `req_ready` is held high at all times, so the block never applies back-pressure. Each accepted request, read or write, gets a `rsp_valid` pulse on the following cycle, with read data on `rsp_rdata` (zero for writes). The requester must accept the response in that cycle, because the response path has no ready input. The open/closed state of the lock is exported on `unlocked` for other key-protected functions. Register map (byte offsets): key register 0x0, reset-trigger register 0x4, its set alias 0x8. Other offsets read as 0 and ignore writes.

Top module: `swkey_reset_trigger`

## Requirements
- R1: While and after a synchronous active-low reset, `unlocked` is 0, `swrst_req` is 0, `rsp_valid` is 0, and the trigger is disarmed.
- R2: A write of 0xAA996655 to offset 0x0, followed by a write of 0x556699AA to offset 0x0, sets `unlocked` in the cycle after the second write. Accesses to other offsets in between do not break the sequence.
- R3: Any other write to offset 0x0 closes the lock. This covers a wrong value, the second word without the first, and any write while open. A write of the first word always restarts the sequence.
- R4: While `unlocked` is 0, writes to offsets 0x4 and 0x8 are ignored: bit 0 of a later read of 0x4 stays 0, and that read raises no `swrst_req`.
- R5: While unlocked, a write with bit 0 set to offset 0x4 or to its alias 0x8 arms the trigger. A read of 0x4 then returns 1 in bit 0.
- R6: A write with bit 0 clear to offset 0x4 or 0x8 neither arms nor disarms the trigger.
- R7: A read of offset 0x4 while armed drives `swrst_req` high for exactly one cycle, the cycle after the read is accepted. In that same cycle the trigger disarms and the lock closes.
- R8: A read of offset 0x4 while disarmed raises no `swrst_req`. Reads of offsets 0x0 and 0x8 never fire and return 0.
- R9: Bits 31 to 1 of every read response are 0.
- R10: `req_ready` is always 1, and every accepted request produces `rsp_valid` for exactly the following cycle.
- R11: A reset while armed and unlocked disarms the trigger and closes the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (4) | Byte offset of the register |
| req_wdata | input | DW (32) | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | DW (32) | Read data (0 for writes) |
| unlocked | output | 1 | Key lock is open |
| swrst_req | output | 1 | One-cycle software reset request to the sequencer |

## Verification
A key state machine stuck in the wrong state shows up at once on `unlocked`, one cycle after the key write that should have moved it. The next arm attempt then also shows it, through bit 0 of the reset-trigger readback. A wrong armed bit is visible on the very next read of 0x4, both in `rsp_rdata[0]` and in `swrst_req` in that response cycle. A pulse that lasts too long, or a lock that fails to close after firing, is caught on the following cycle.

// File: rtl/swkey_pkg.sv
package swkey_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_FIRST  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam int NREG = 3;
  localparam int IDX_KEY = 0;
  localparam int IDX_SWR = 1;
  localparam int IDX_SET = 2;
endpackage

// File: rtl/swkey_decode.sv
module swkey_decode #(
  parameter int AW = 4,
  parameter logic [AW-1:0] KEY_OFF = 4'h0,
  parameter logic [AW-1:0] SWR_OFF = 4'h4,
  parameter logic [AW-1:0] SET_OFF = 4'h8
) (
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  output logic          key_wr,
  output logic          arm_wr,
  output logic          trig_rd
);
  import swkey_pkg::*;

  localparam logic [AW-1:0] OFFS [NREG] = '{KEY_OFF, SWR_OFF, SET_OFF};

  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = req_valid && (req_addr == OFFS[g]);
  end

  assign key_wr  = hit[IDX_KEY] && req_write;
  assign arm_wr  = (hit[IDX_SWR] || hit[IDX_SET]) && req_write;
  assign trig_rd = hit[IDX_SWR] && !req_write;
endmodule

// File: rtl/swkey_keyfsm.sv
module swkey_keyfsm #(
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY_A = 32'hAA996655,
  parameter logic [DW-1:0] KEY_B = 32'h556699AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [DW-1:0] wdata,
  input  logic          relock,
  output logic          unlocked
);
  import swkey_pkg::*;

  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (relock) begin
      st_d = KS_LOCKED;
    end else if (key_wr) begin
      if (wdata == KEY_A)                         st_d = KS_FIRST;
      else if (wdata == KEY_B && st_q == KS_FIRST) st_d = KS_OPEN;
      else                                         st_d = KS_LOCKED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= KS_LOCKED;
    else        st_q <= st_d;
  end

  assign unlocked = (st_q == KS_OPEN);
endmodule

// File: rtl/swkey_arm.sv
module swkey_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr,
  input  logic arm_bit,
  input  logic unlocked,
  input  logic trig_rd,
  output logic armed,
  output logic fire_now,
  output logic fire_q
);
  assign fire_now = trig_rd && armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= fire_now;
      if (fire_now)                            armed <= 1'b0;
      else if (arm_wr && arm_bit && unlocked)  armed <= 1'b1;
    end
  end
endmodule

// File: rtl/swkey_resp.sv
module swkey_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          trig_rd,
  input  logic          armed,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= '0;
      if (trig_rd) rsp_rdata[0] <= armed;
    end
  end
endmodule

// File: rtl/swkey_reset_trigger.sv
module swkey_reset_trigger #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter logic [AW-1:0] KEY_OFF = 4'h0,
  parameter logic [AW-1:0] SWR_OFF = 4'h4,
  parameter logic [AW-1:0] SET_OFF = 4'h8,
  parameter logic [DW-1:0] KEY_A = 32'hAA996655,
  parameter logic [DW-1:0] KEY_B = 32'h556699AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          unlocked,
  output logic          swrst_req
);
  logic key_wr, arm_wr, trig_rd;
  logic armed, fire_now;

  assign req_ready = 1'b1;

  swkey_decode #(
    .AW(AW), .KEY_OFF(KEY_OFF), .SWR_OFF(SWR_OFF), .SET_OFF(SET_OFF)
  ) i_decode (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .key_wr(key_wr), .arm_wr(arm_wr), .trig_rd(trig_rd)
  );

  swkey_keyfsm #(.DW(DW), .KEY_A(KEY_A), .KEY_B(KEY_B)) i_keyfsm (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .wdata(req_wdata),
    .relock(fire_now), .unlocked(unlocked)
  );

  swkey_arm i_arm (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .arm_bit(req_wdata[0]),
    .unlocked(unlocked), .trig_rd(trig_rd), .armed(armed),
    .fire_now(fire_now), .fire_q(swrst_req)
  );

  swkey_resp #(.DW(DW)) i_resp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .trig_rd(trig_rd),
    .armed(armed), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/swkey_chk.sv
module swkey_chk #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter logic [AW-1:0] KEY_OFF = 4'h0,
  parameter logic [AW-1:0] SWR_OFF = 4'h4,
  parameter logic [DW-1:0] KEY_B = 32'h556699AA
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          unlocked,
  input logic          swrst_req,
  input logic          armed
);
  // R2
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(req_valid && req_write && req_addr == KEY_OFF && req_wdata == KEY_B));

  // R4
  arm_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(unlocked));

  // R7
  fire_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_req |-> $past(req_valid && !req_write && req_addr == SWR_OFF));

  // R7
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_req |=> !swrst_req);

  // R7
  fire_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_req |-> (!unlocked && !armed));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata >> 1) == '0));

  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  rsp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
endmodule

bind swkey_reset_trigger swkey_chk #(
  .AW(AW), .DW(DW), .KEY_OFF(KEY_OFF), .SWR_OFF(SWR_OFF), .KEY_B(KEY_B)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .unlocked(unlocked), .swrst_req(swrst_req),
  .armed(armed)
);

// File: tb/test_swkey_reset_trigger.sv
module test_swkey_reset_trigger;
  localparam logic [3:0]  A_KEY = 4'h0, A_SWR = 4'h4, A_SET = 4'h8, A_NONE = 4'hC;
  localparam logic [31:0] KA = 32'hAA996655, KB = 32'h556699AA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        unlocked;
  logic        swrst_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_ks = 0;
  bit m_arm = 0;

  always #4 clk = ~clk;

  swkey_reset_trigger i_swkey_reset_trigger (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .unlocked(unlocked),
    .swrst_req(swrst_req)
  );

  function automatic int next_ks(int ks, logic [31:0] d);
    if (d == KA) return 1;
    if (d == KB && ks == 1) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] exp_rdata(bit w, logic [3:0] a, bit arm);
    if (!w && a == A_SWR) return {31'b0, arm};
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(bit w, logic [3:0] a, logic [31:0] d);
    logic [31:0] er;
    bit ep;
    er = exp_rdata(w, a, m_arm);
    ep = !w && a == A_SWR && m_arm;
    if (w) begin
      if (a == A_KEY) m_ks = next_ks(m_ks, d);
      else if ((a == A_SWR || a == A_SET) && d[0] && m_ks == 2) m_arm = 1;
    end else if (ep) begin
      m_arm = 0;
      m_ks = 0;
    end
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    check(a == A_SWR ? "R5 rdata" : "R8 rdata", rsp_rdata, er);
    check("R7 swrst_req", {31'b0, swrst_req}, {31'b0, ep});
    check("R2 unlocked", {31'b0, unlocked}, {31'b0, m_ks == 2});
  endtask

  task automatic idle_chk();
    @(posedge clk);
    @(negedge clk);
    check("R10 idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R7 idle swrst_req", {31'b0, swrst_req}, 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_ks = 0; m_arm = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic open_lock();
    do_req(1, A_KEY, KA);
    do_req(1, A_KEY, KB);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 unlocked", {31'b0, unlocked}, 32'd0);
    check("R1 swrst_req", {31'b0, swrst_req}, 32'd0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R10 req_ready", {31'b0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 arm while locked ignored
    do_req(1, A_SWR, 32'h1);
    do_req(1, A_SET, 32'hFFFF_FFFF);
    do_req(0, A_SWR, 32'h0);
    check("R4 locked no arm", {31'b0, m_arm}, 32'd0);

    // R3 wrong order / wrong value
    do_req(1, A_KEY, KB);
    do_req(1, A_KEY, KA);
    do_req(1, A_KEY, 32'h1234_5678);
    do_req(1, A_KEY, KB);
    check("R3 stays locked", {31'b0, unlocked}, 32'd0);
    // R2 with an unrelated access between the two words
    do_req(1, A_KEY, KA);
    do_req(0, A_NONE, 32'h0);
    do_req(1, A_KEY, KB);
    check("R2 open after gap", {31'b0, unlocked}, 32'd1);
    // R3 write while open relocks
    do_req(1, A_KEY, 32'h0);
    check("R3 relock", {31'b0, unlocked}, 32'd0);

    // R6 zero writes do nothing
    open_lock();
    do_req(1, A_SWR, 32'hFFFF_FFFE);
    do_req(0, A_SWR, 32'h0);
    check("R6 no arm", {31'b0, swrst_req}, 32'd0);
    // R5 arm through alias, R8 alias/key reads do not fire
    do_req(1, A_SET, 32'h1);
    do_req(1, A_SWR, 32'h0);
    do_req(0, A_SET, 32'h0);
    do_req(0, A_KEY, 32'h0);
    // R7 fire
    do_req(0, A_SWR, 32'h0);
    idle_chk();
    check("R7 relocked", {31'b0, unlocked}, 32'd0);
    // R8 read while disarmed
    do_req(0, A_SWR, 32'h0);

    // R11 reset while armed
    open_lock();
    do_req(1, A_SWR, 32'h1);
    do_reset();
    @(negedge clk);
    check("R11 unlocked", {31'b0, unlocked}, 32'd0);
    do_req(0, A_SWR, 32'h0);
    check("R11 no fire", {31'b0, swrst_req}, 32'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      bit w;
      case ($urandom % 4)
        0: a = A_KEY;
        1: a = A_SWR;
        2: a = A_SET;
        default: a = ($urandom % 3 == 0) ? A_NONE : A_SWR;
      endcase
      case ($urandom % 6)
        0: d = KA;
        1: d = KB;
        2: d = 32'h1;
        3: d = 32'h0;
        4: d = $urandom;
        default: d = $urandom | 32'h1;
      endcase
      w = ($urandom % 5) < 3;
      if ($urandom % 8 == 0) open_lock();
      if ($urandom % 10 == 0) idle_chk();
      do_req(w, a, d);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule